// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Driver

This block turns a serial bit stream into a bank of parallel driver controls, for example for the columns of a display or the nozzles of a print head. A slow shift clock moves bits into a register, one bit per high-to-low transition of that clock. A latch-enable level moves the register contents into a holding stage. While the enable stays high the holding stage is transparent. When the enable drops, the holding stage keeps its last value. Before the held bits reach the pins, two level controls condition them. One blanks every output. The other selects whether the held data is presented true or inverted.

The last register stage is brought out as a serial output, so several instances can be chained on one data line. A parameter fixes the shift order at elaboration time. The shift clock, serial data and latch enable arrive from outside the core clock domain. They share one resynchronizer of `SYNC_STAGES` flops, so their relative timing is kept. The module clock `clk` samples them, and a falling edge of the resynchronized shift clock triggers each shift.

Top module: `sipo_latched_driver`

## Requirements
- R1: While `rst_n` is low and after its release, the shift register and the holding stage are all zero, so with `polarity`=1 and `blank`=0 every `par_out` bit is 0 and `ser_out` is 0.
- R2: The register advances only on a 1-to-0 transition of the resynchronized `shift_clk`. A 0-to-1 transition or a steady level leaves it unchanged.
- R3: With `DIR`=SHIFT_UP, each shift moves bit i into bit i+1, and `ser_in` enters bit 0.
- R4: With `DIR`=SHIFT_DOWN, each shift moves bit i into bit i-1, and `ser_in` enters bit `WIDTH`-1.
- R5: While the resynchronized `latch_en` is 1, the holding stage shows the current register contents.
- R6: While the resynchronized `latch_en` is 0, the holding stage keeps its value. If the enable falls in the same input step as a shift edge, it keeps the contents from before that shift.
- R7: With `blank`=1, every `par_out` bit is 0 whatever the holding stage and `polarity` are.
- R8: With `blank`=0, `par_out` equals the holding stage when `polarity`=1 and its bitwise inverse when `polarity`=0.
- R9: `ser_out` equals the stage that data leaves from: bit `WIDTH`-1 for SHIFT_UP and bit 0 for SHIFT_DOWN.
- R10: A change on `shift_clk`, `ser_in` or `latch_en` takes effect no later than `SYNC_STAGES`+1 rising edges of `clk` after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk | input | 1 | Serial shift clock; a falling edge shifts |
| ser_in | input | 1 | Serial data in |
| latch_en | input | 1 | Holding stage transparent while high |
| blank | input | 1 | Forces all parallel outputs to 0 |
| polarity | input | 1 | 1 = true data, 0 = inverted data |
| par_out | output | WIDTH | Conditioned parallel outputs |
| ser_out | output | 1 | Cascade output, last register stage |

## Verification
The hardest case to reach is a shift edge in the same input step as a change of latch enable, because the held value then depends on the order of capture and shift. The random stimulus toggles the shift clock, latch enable, blank and polarity independently in every step, so both rising and falling enable changes meet shift edges many times. Two instances, one for each shift order, run in parallel from the same stimulus.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
   typedef enum logic {
      SHIFT_UP   = 1'b0,
      SHIFT_DOWN = 1'b1
   } shift_dir_e;

   localparam int unsigned SYNC_IDX_CLK  = 0;
   localparam int unsigned SYNC_IDX_DATA = 1;
   localparam int unsigned SYNC_IDX_LE   = 2;
   localparam int unsigned SYNC_LANES    = 3;
endpackage

// File: rtl/sipo_input_sync.sv
module sipo_input_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned LANES  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] async_in,
   output logic [LANES-1:0] sync_out
);
   if (STAGES < 1) begin : g_bad_stages
      $error("sipo_input_sync: STAGES must be at least 1");
   end

   logic [LANES-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/sipo_fall_detect.sv
module sipo_fall_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic fall
);
   logic level_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= level;
   end

   assign fall = level_d & ~level;
endmodule

// File: rtl/sipo_shift_core.sv
module sipo_shift_core
   import sipo_pkg::*;
#(
   parameter int unsigned WIDTH = 32,
   parameter shift_dir_e  DIR   = SHIFT_UP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             din,
   output logic [WIDTH-1:0] bits,
   output logic             dout
);
   if (WIDTH < 2) begin : g_bad_width
      $error("sipo_shift_core: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] bits_nxt;

   if (DIR == SHIFT_UP) begin : g_up
      assign bits_nxt = {bits[WIDTH-2:0], din};
      assign dout     = bits[WIDTH-1];
   end else begin : g_down
      assign bits_nxt = {din, bits[WIDTH-1:1]};
      assign dout     = bits[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bits <= '0;
      else if (step) bits <= bits_nxt;
   end

   // R2: no movement without a detected falling edge
   a_r2_hold_without_edge: assert property (
      @(posedge clk) disable iff (!rst_n) !step |=> $stable(bits));
endmodule

// File: rtl/sipo_hold_latch.sv
module sipo_hold_latch #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held <= '0;
      else if (open) held <= d;
   end

   assign q = open ? d : held;

   // R6: a closed holding stage keeps its contents
   a_r6_closed_holds: assert property (
      @(posedge clk) disable iff (!rst_n) !open |=> $stable(held));
endmodule

// File: rtl/sipo_out_cond.sv
module sipo_out_cond #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] data,
   input  logic             blank,
   input  logic             polarity,
   output logic [WIDTH-1:0] drive
);
   logic [WIDTH-1:0] oriented;

   assign oriented = polarity ? data : ~data;
   assign drive    = blank ? '0 : oriented;
endmodule

// File: rtl/sipo_latched_driver.sv
module sipo_latched_driver
   import sipo_pkg::*;
#(
   parameter int unsigned WIDTH       = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter shift_dir_e  DIR         = SHIFT_UP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_clk,
   input  logic             ser_in,
   input  logic             latch_en,
   input  logic             blank,
   input  logic             polarity,
   output logic [WIDTH-1:0] par_out,
   output logic             ser_out
);
   localparam int unsigned FEED_IDX = (DIR == SHIFT_UP) ? WIDTH - 2 : 1;

   logic [SYNC_LANES-1:0] raw_in;
   logic [SYNC_LANES-1:0] synced;
   logic                  shift_step;
   logic [WIDTH-1:0]      shreg;
   logic [WIDTH-1:0]      latched;

   assign raw_in[SYNC_IDX_CLK]  = shift_clk;
   assign raw_in[SYNC_IDX_DATA] = ser_in;
   assign raw_in[SYNC_IDX_LE]   = latch_en;

   sipo_input_sync #(.STAGES(SYNC_STAGES), .LANES(SYNC_LANES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (raw_in),
      .sync_out (synced)
   );

   sipo_fall_detect u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (synced[SYNC_IDX_CLK]),
      .fall  (shift_step)
   );

   sipo_shift_core #(.WIDTH(WIDTH), .DIR(DIR)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (shift_step),
      .din   (synced[SYNC_IDX_DATA]),
      .bits  (shreg),
      .dout  (ser_out)
   );

   sipo_hold_latch #(.WIDTH(WIDTH)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .open  (synced[SYNC_IDX_LE]),
      .d     (shreg),
      .q     (latched)
   );

   sipo_out_cond #(.WIDTH(WIDTH)) u_cond (
      .data     (latched),
      .blank    (blank),
      .polarity (polarity),
      .drive    (par_out)
   );

   // R5: open holding stage shows the register on the pins (true polarity)
   a_r5_transparent: assert property (
      @(posedge clk) disable iff (!rst_n)
      (synced[SYNC_IDX_LE] && !blank && polarity) |-> par_out == shreg);

   // R7: blanking overrides everything
   a_r7_blank_zero: assert property (
      @(posedge clk) disable iff (!rst_n) blank |-> par_out == '0);

   // R8: inverted presentation of held data
   a_r8_inverted: assert property (
      @(posedge clk) disable iff (!rst_n)
      (!blank && !polarity) |-> par_out == ~latched);

   // R9: cascade output takes the neighbouring stage after a shift
   a_r9_cascade_follows: assert property (
      @(posedge clk) disable iff (!rst_n)
      shift_step |=> ser_out == $past(shreg[FEED_IDX]));
endmodule

// File: tb/sipo_latched_driver_tb.sv
module sipo_latched_driver_tb;
   import sipo_pkg::*;

   localparam int W       = 32;
   localparam int CLK_PER = 10;
   localparam int PHASE   = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic shift_clk = 1'b1, ser_in = 1'b0, latch_en = 1'b0;
   logic blank = 1'b0, polarity = 1'b1;
   logic [W-1:0] pout_up, pout_dn;
   logic sout_up, sout_dn;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PER/2) clk = ~clk;

   sipo_latched_driver #(.WIDTH(W), .SYNC_STAGES(2), .DIR(SHIFT_UP)) u_dut (
      .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .ser_in(ser_in),
      .latch_en(latch_en), .blank(blank), .polarity(polarity),
      .par_out(pout_up), .ser_out(sout_up));

   sipo_latched_driver #(.WIDTH(W), .SYNC_STAGES(2), .DIR(SHIFT_DOWN)) u_dut_rev (
      .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .ser_in(ser_in),
      .latch_en(latch_en), .blank(blank), .polarity(polarity),
      .par_out(pout_dn), .ser_out(sout_dn));

   // behavioural reference: two bit arrays per direction
   bit m_reg_up [W];
   bit m_reg_dn [W];
   bit m_hold_up [W];
   bit m_hold_dn [W];
   bit m_sclk = 1'b1;
   bit m_le   = 1'b0;

   function automatic logic [W-1:0] pack(input bit a [W]);
      logic [W-1:0] v;
      for (int i = 0; i < W; i++) v[i] = a[i];
      return v;
   endfunction

   function automatic logic [W-1:0] expect_pins(input bit a [W], input bit bl, input bit po);
      logic [W-1:0] v;
      v = pack(a);
      if (bl) return '0;
      if (!po) return ~v;
      return v;
   endfunction

   task automatic check_vec(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   function automatic string pin_tag(input bit bl, input bit po, input bit le, input bit edge_rise);
      if (bl)        return "R7 blank";
      if (!po)       return "R8 invert";
      if (le)        return "R5 transparent";
      if (edge_rise) return "R2 rise-no-shift";
      return "R6 hold";
   endfunction

   // one input step: drive, wait SYNC_STAGES+1 and more edges (R10), update model, compare
   task automatic step(input bit sc, input bit si, input bit le, input bit bl, input bit po);
      bit fall_ev, rise_ev;
      @(negedge clk);
      shift_clk = sc; ser_in = si; latch_en = le; blank = bl; polarity = po;
      repeat (PHASE - 1) @(negedge clk);
      fall_ev = m_sclk && !sc;
      rise_ev = !m_sclk && sc;
      if (m_le) begin
         m_hold_up = m_reg_up;
         m_hold_dn = m_reg_dn;
      end
      if (fall_ev) begin
         for (int i = W - 1; i > 0; i--) m_reg_up[i] = m_reg_up[i-1];
         m_reg_up[0] = si;
         for (int i = 0; i < W - 1; i++) m_reg_dn[i] = m_reg_dn[i+1];
         m_reg_dn[W-1] = si;
      end
      if (le) begin
         m_hold_up = m_reg_up;
         m_hold_dn = m_reg_dn;
      end
      m_sclk = sc;
      m_le   = le;
      check_vec({"R3 up ", pin_tag(bl, po, le, rise_ev)}, pout_up, expect_pins(m_hold_up, bl, po));
      check_vec({"R4 down ", pin_tag(bl, po, le, rise_ev)}, pout_dn, expect_pins(m_hold_dn, bl, po));
      check_bit("R9 cascade up", sout_up, m_reg_up[W-1]);
      check_bit("R9 cascade down", sout_dn, m_reg_dn[0]);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1: reset state
      check_vec("R1 reset pins up", pout_up, '0);
      check_vec("R1 reset pins down", pout_dn, '0);
      check_bit("R1 reset cascade", sout_up, 1'b0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check_vec("R1 after release", pout_up, '0);
      check_bit("R1 after release cascade", sout_dn, 1'b0);

      // directed fill: single 1 walks with transparent holding stage
      for (int k = 0; k < W + 2; k++) begin
         step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
         step(1'b0, (k == 0), 1'b1, 1'b0, 1'b1);
      end
      // close, shift more: pins frozen (R6), register keeps moving (R9)
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      for (int k = 0; k < 6; k++) begin
         step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
         step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      end
      // enable drop together with a shift edge (R6 ordering)
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0); // R7 over R8
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R8

      // random sequences
      for (int n = 0; n < 1500; n++) begin
         bit sc, si, le, bl, po;
         sc = (($urandom % 3) != 0) ? ~shift_clk : shift_clk;
         si = $urandom;
         le = (($urandom % 5) == 0) ? ~latch_en : latch_en;
         bl = (($urandom % 8) == 0);
         po = (($urandom % 4) != 0);
         step(sc, si, le, bl, po);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule